// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the general-purpose register store of a small 8-bit CPU. It holds thirty-two byte-wide registers. Two combinational read ports supply the two ALU operands. One byte write port takes the ALU result on the rising clock edge, so an operation reads, computes and writes back in the same cycle.

The top six registers also serve as three 16-bit address pointers for indirect data-space access. Select codes 0, 1 and 2 pick the pointers X, Y and Z. Each pointer is built from an even-indexed low byte and the odd-indexed high byte above it: X uses 26 and 27, Y uses 28 and 29, Z uses 30 and 31. A 16-bit pointer port reads the selected pointer as a word. It can also write an adjusted word back in one edge, which lets the surrounding logic implement post-increment and pre-decrement addressing. The Z pointer is also driven out on its own output at all times, for use as a program-memory table address.

Top module: `rfp_regfile`

## Requirements
- R1: A clock edge with `rst_n` low clears all 32 registers to zero.
- R2: With `wr_en` high, `wr_data` is stored at `wr_addr` on the clock edge and is visible on both read ports from the next cycle. With `wr_en` low, no register changes.
- R3: Both read ports are combinational and independent of each other. In the cycle of a write, a read of the written register returns the value held before the edge (there is no bypass).
- R4: Pointer select code 0 maps to registers 27:26, code 1 to 29:28 and code 2 to 31:30. The high byte is the odd register, which is bits 15:8 of the word.
- R5: With `ptr_wr_en` high and a valid select, both bytes of the selected pointer take `ptr_wr_data` on the same edge. The new word is visible on `ptr_rd_data` and on the byte read ports in the next cycle.
- R6: When the byte write port and the pointer write port target the same register on one edge, that register takes `wr_data`. The other byte of the pointer still takes its part of `ptr_wr_data`.
- R7: `z_ptr` always equals {register 31, register 30}.
- R8: Select code 3 reads as 0x0000 on `ptr_rd_data`, and a pointer write with code 3 changes no register.
- R9: Byte writes to registers 26 to 31 are seen as the matching byte of the pointer word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_addr | input | 5 | Register index for operand port A |
| rd_a_data | output | 8 | Operand A |
| rd_b_addr | input | 5 | Register index for operand port B |
| rd_b_data | output | 8 | Operand B |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write index |
| wr_data | input | 8 | Byte write value |
| ptr_sel | input | 2 | Pointer select: 0 = X, 1 = Y, 2 = Z, 3 = none |
| ptr_rd_data | output | 16 | Selected pointer word |
| ptr_wr_en | input | 1 | Pointer word write enable |
| ptr_wr_data | input | 16 | Pointer word write value |
| z_ptr | output | 16 | Z pointer word, always driven |

## Verification
First, every register index is written once with a value computed from its index, and both ports then read the whole file. Distinct values catch any decode that aliases two addresses, and reading the written register in the write cycle separates a correct design from one that bypasses. Each pointer select is then written with words whose two bytes differ, which exposes swapped byte halves or a wrong pair. Byte and pointer writes aimed at the low byte and then the high byte of each pointer on the same edge show which port wins, byte by byte. A long random mix of writes and reads, compared against a reference array and with `z_ptr` checked in every cycle, catches interactions that the directed patterns miss.

// File: rtl/rfp_pkg.sv
// Package: shared sizes and the pointer select encoding for the register file.
// Assumes the three pointers occupy the top six registers in consecutive pairs.
package rfp_pkg;
    typedef enum logic [1:0] {
        PSEL_X    = 2'd0,
        PSEL_Y    = 2'd1,
        PSEL_Z    = 2'd2,
        PSEL_NONE = 2'd3
    } ptr_sel_e;
endpackage

// File: rtl/rfp_ptr_map.sv
// Module: rfp_ptr_map
// Turns a pointer select code into the index of the pointer's low byte and a
// valid flag. The high byte always sits at the next index up.
// Assumes PTR_BASE is even and PTR_BASE + 5 < NUM_REGS.
module rfp_ptr_map #(
    parameter int NUM_REGS = 32,
    parameter int PTR_BASE = 26,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [1:0]        sel,
    output logic              valid,
    output logic [ADDR_W-1:0] lo_idx,
    output logic [ADDR_W-1:0] hi_idx
);
    import rfp_pkg::*;

    ptr_sel_e sel_e;
    assign sel_e = ptr_sel_e'(sel);

    // Decode the select into the low-byte index of the chosen pair.
    always_comb begin
        valid  = 1'b1;
        lo_idx = ADDR_W'(PTR_BASE);
        unique case (sel_e)
            PSEL_X:    lo_idx = ADDR_W'(PTR_BASE);
            PSEL_Y:    lo_idx = ADDR_W'(PTR_BASE + 2);
            PSEL_Z:    lo_idx = ADDR_W'(PTR_BASE + 4);
            default:   valid  = 1'b0;
        endcase
    end

    // The high byte is the odd register just above the low byte.
    assign hi_idx = lo_idx | ADDR_W'(1);
endmodule

// File: rtl/rfp_store.sv
// Module: rfp_store
// Holds the registers and applies the byte write and the pointer word write on
// the rising edge. The byte write wins on any register that both ports target.
// Assumes pw_en is already qualified by a valid pointer select.
module rfp_store #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int PTR_W   = 2 * DATA_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             pw_en,
    input  logic [ADDR_W-1:0]                pw_lo_idx,
    input  logic [ADDR_W-1:0]                pw_hi_idx,
    input  logic [PTR_W-1:0]                 pw_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    // Update every register: reset, then byte write, then pointer halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en && wr_addr == ADDR_W'(i)) begin
                    regs_q[i] <= wr_data;
                end else if (pw_en && pw_lo_idx == ADDR_W'(i)) begin
                    regs_q[i] <= pw_data[DATA_W-1:0];
                end else if (pw_en && pw_hi_idx == ADDR_W'(i)) begin
                    regs_q[i] <= pw_data[PTR_W-1:DATA_W];
                end
            end
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_q == '0));

    // R2
    byte_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

    // R6
    byte_beats_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pw_en && (wr_addr == pw_lo_idx || wr_addr == pw_hi_idx))
        |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !pw_en) |=> $stable(regs_q));
endmodule

// File: rtl/rfp_rd_port.sv
// Module: rfp_rd_port
// One combinational read port: selects a register by index.
// Assumes NUM_REGS is a power of two, so every index is in range.
module rfp_rd_port #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ADDR_W-1:0]               addr,
    output logic [DATA_W-1:0]               data
);
    // Plain index mux; no bypass of same-cycle writes.
    assign data = regs[addr];
endmodule

// File: rtl/rfp_regfile.sv
// Module: rfp_regfile (top)
// Register file with two byte read ports, one byte write port, a 16-bit pointer
// read/write port over the top six registers, and an always-on Z word output.
// Assumes the owner never needs a write to be visible in the same cycle.
module rfp_regfile #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    parameter int PTR_BASE = 26,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int PTR_W   = 2 * DATA_W,
    localparam int N_RD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        ptr_sel,
    output logic [PTR_W-1:0]  ptr_rd_data,
    input  logic              ptr_wr_en,
    input  logic [PTR_W-1:0]  ptr_wr_data,
    output logic [PTR_W-1:0]  z_ptr
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic                            psel_valid;
    logic [ADDR_W-1:0]               plo_idx;
    logic [ADDR_W-1:0]               phi_idx;
    logic [N_RD-1:0][ADDR_W-1:0]     rd_addr;
    logic [N_RD-1:0][DATA_W-1:0]     rd_data;

    rfp_ptr_map #(.NUM_REGS(NUM_REGS), .PTR_BASE(PTR_BASE)) u_map (
        .sel    (ptr_sel),
        .valid  (psel_valid),
        .lo_idx (plo_idx),
        .hi_idx (phi_idx)
    );

    rfp_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pw_en     (ptr_wr_en && psel_valid),
        .pw_lo_idx (plo_idx),
        .pw_hi_idx (phi_idx),
        .pw_data   (ptr_wr_data),
        .regs_q    (regs_q)
    );

    // Gather the operand addresses so the ports can be generated.
    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        rfp_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
            .regs (regs_q),
            .addr (rd_addr[p]),
            .data (rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    // Pointer word read: the selected pair, or zero for the unused code.
    assign ptr_rd_data = psel_valid ? {regs_q[phi_idx], regs_q[plo_idx]} : '0;

    // Z word for program-memory table lookups, always driven.
    assign z_ptr = {regs_q[PTR_BASE + 5], regs_q[PTR_BASE + 4]};

    // R5
    ptr_word_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr_en && psel_valid && !(wr_en && (wr_addr == plo_idx || wr_addr == phi_idx)))
        |=> ((ptr_sel != $past(ptr_sel)) || (ptr_rd_data == $past(ptr_wr_data))));

    // R7
    z_matches_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sel == 2'd2) |-> (z_ptr == ptr_rd_data));

    // R8
    none_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr_en && !psel_valid && !wr_en) |=> $stable(z_ptr));

    // R8
    none_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sel == 2'd3) |-> (ptr_rd_data == '0));
endmodule

// File: tb/tb_rfp_regfile.sv
`timescale 1ns/1ps
module tb_rfp_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [7:0]  rd_a_data, rd_b_data, wr_data;
    logic        wr_en, ptr_wr_en;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_rd_data, ptr_wr_data, z_ptr;

    logic [7:0]  mdl [32];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    rfp_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr_sel(ptr_sel), .ptr_rd_data(ptr_rd_data),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
        .z_ptr(z_ptr)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] ptr_exp(input logic [1:0] s);
        if (s == 2'd3) return 16'h0000;
        return {mdl[27 + 2*int'(s)], mdl[26 + 2*int'(s)]};
    endfunction

    // One cycle of stimulus: drive after a falling edge, check before and after the rising edge.
    task automatic cyc(input string req, input bit we, input logic [4:0] wa, input logic [7:0] wd,
                       input bit pe, input logic [1:0] ps, input logic [15:0] pd,
                       input logic [4:0] rb);
        wr_en = we; wr_addr = wa; wr_data = wd;
        ptr_wr_en = pe; ptr_sel = ps; ptr_wr_data = pd;
        rd_a_addr = wa; rd_b_addr = rb;
        #1;
        chk("R3 no bypass", {8'h0, rd_a_data}, {8'h0, mdl[wa]});
        chk("R3 port B", {8'h0, rd_b_data}, {8'h0, mdl[rb]});
        @(posedge clk);
        if (pe && ps != 2'd3) begin
            mdl[26 + 2*int'(ps)] = pd[7:0];
            mdl[27 + 2*int'(ps)] = pd[15:8];
        end
        if (we) mdl[wa] = wd;
        @(negedge clk);
        wr_en = 1'b0; ptr_wr_en = 1'b0;
        #1;
        chk(req, {8'h0, rd_a_data}, {8'h0, mdl[wa]});
        chk(req, {8'h0, rd_b_data}, {8'h0, mdl[rb]});
        chk(req, ptr_rd_data, ptr_exp(ps));
        chk("R7 z word", z_ptr, {mdl[31], mdl[30]});
        @(negedge clk);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_a_addr = 5'(i); rd_b_addr = 5'(31 - i);
            #1;
            chk(req, {8'h0, rd_a_data}, {8'h0, mdl[i]});
            chk(req, {8'h0, rd_b_data}, {8'h0, mdl[31 - i]});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; ptr_wr_en = 0;
        ptr_sel = 0; ptr_wr_data = 0; rd_a_addr = 0; rd_b_addr = 0;
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        @(negedge clk);
        do_reset();
        // R1 reset state
        sweep("R1 reset");
        chk("R1 z after reset", z_ptr, 16'h0000);

        // R2 exhaustive byte writes with index-derived values
        for (int i = 0; i < 32; i++)
            cyc("R2 byte write", 1'b1, 5'(i), 8'(i * 37 + 5), 1'b0, 2'd3, 16'h0, 5'(i ^ 31));
        sweep("R2 full sweep");
        // R2 write enable low leaves the file alone
        for (int i = 0; i < 32; i++)
            cyc("R2 disabled write", 1'b0, 5'(i), 8'hA5, 1'b0, 2'd3, 16'h0, 5'(i ^ 7));
        // R9 / R4 byte writes show up inside pointer words
        for (int s = 0; s < 3; s++) begin
            cyc("R9 low byte", 1'b1, 5'(26 + 2*s), 8'(8'h10 + s), 1'b0, 2'(s), 16'h0, 5'd0);
            cyc("R9 high byte", 1'b1, 5'(27 + 2*s), 8'(8'hC0 + s), 1'b0, 2'(s), 16'h0, 5'd1);
            chk("R4 pair order", ptr_rd_data, {8'(8'hC0 + s), 8'(8'h10 + s)});
        end
        // R5 / R4 pointer word writes
        for (int s = 0; s < 3; s++)
            cyc("R5 ptr write", 1'b0, 5'(26 + 2*s), 8'h0, 1'b1, 2'(s), 16'(16'h1234 * (s + 1) + 16'h0F0E), 5'(27 + 2*s));
        sweep("R4 map sweep");
        // R8 unused code: reads zero, write ignored
        cyc("R8 none write", 1'b0, 5'd30, 8'h0, 1'b1, 2'd3, 16'hDEAD, 5'd26);
        sweep("R8 unchanged");
        // R6 conflict on low byte, then on high byte, for each pointer
        for (int s = 0; s < 3; s++) begin
            cyc("R6 low conflict", 1'b1, 5'(26 + 2*s), 8'h5A, 1'b1, 2'(s), 16'hBEEF, 5'(27 + 2*s));
            cyc("R6 high conflict", 1'b1, 5'(27 + 2*s), 8'h3C, 1'b1, 2'(s), 16'hCAFE, 5'(26 + 2*s));
            cyc("R6 elsewhere", 1'b1, 5'(3 + s), 8'h77, 1'b1, 2'(s), 16'hF00D, 5'(26 + 2*s));
        end
        // R2 R5 R6 R7 random mix against the reference array
        for (int k = 0; k < 3000; k++)
            cyc("R7 random mix", 1'($urandom), 5'($urandom), 8'($urandom), 1'($urandom),
                2'($urandom), 16'($urandom), 5'($urandom));
        sweep("R2 final sweep");
        // R1 reset mid-run
        do_reset();
        sweep("R1 second reset");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule